// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block walks a freshly powered memory card from reset through identification and into four-bit transfer mode, without software involvement. It drives a command-issue port that belongs to a separate command-line engine: for each step it presents a command index, a 32-bit argument and the expected response shape, then waits for that engine to report completion together with the response bits and two error flags (CRC mismatch, response timeout).

Along the way it probes for a second-generation card with the interface-condition command, polls the operating-condition application command until the card leaves its busy phase, reads the 128-bit identification register, obtains the relative card address, selects the card and waits for it to reach the transfer state, and finally switches the bus to four data lines. A `tick_i` strobe, for example once per millisecond, measures the two bounded polling loops. When the flow ends, a one-cycle `done_o` pulse reports the outcome. On failure, `fail_o` rises with it and a step-specific code is given. The captured operating-condition word, identification register and card address stay on the outputs until the next start.

Top module: `sdinit_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `fail_o` and `cmd_req_o` are low, `err_code_o` is 0 and the captured OCR, CID and RCA read as zero.
- R2: A start issues command 0 first, with argument 0 and no response expected. Error flags returned for any command that expects no response (0, 7, 6) are ignored.
- R3: The second command is index 8 with argument 0x1AA and a short response. `v2_card_o` is set only when it completes without CRC error or timeout and response bits 11:0 equal 0x1AA. A failed index-8 exchange is not a failure and the flow continues.
- R4: Index 55 (argument 0, short response) and index 41 are then sent as a pair, repeatedly, until bit 31 of the index-41 response is 1. The index-41 argument is 0x00FF8000, with bit 30 set exactly when `v2_card_o` is 1. The final index-41 response is captured on `ocr_o`.
- R5: An index-41 response with bit 31 clear, arriving once at least `ACMD_TICKS` ticks have passed since the index-8 completion, ends the flow with code 3.
- R6: Index 2 is sent with a long response, captured whole on `cid_o`. Index 3 follows with a short response; its bits 31:16 become `rca_o`.
- R7: Index 7 is sent with argument {RCA,16'h0} and no response. Index 13 with the same argument and a short response is then repeated until response bits 12:9 equal 4. A non-4 status arriving once at least `STATUS_TICKS` ticks have passed since the index-7 completion ends the flow with code 7.
- R8: After the transfer state is reached, index 55 with argument {RCA,16'h0} and a short response is sent, then index 6 with argument 2 and no response. Its completion ends the flow with code 0.
- R9: A CRC error or response timeout on a response-bearing command other than index 8 ends the flow. The codes are 1 for the first-loop index 55, 2 for index 41, 4 for index 2, 5 for index 3, 6 for index 13 and 8 for the bus-setup index 55.
- R10: `done_o` is a one-cycle pulse in the cycle after the final completion, with `busy_o` already low. `fail_o` pulses with it when the code is non-zero, and `err_code_o` holds the code until the next start.
- R11: A start while busy is ignored. Captured results stay constant while idle, and are cleared (together with `v2_card_o` and the code) when a start is accepted.
- R12: `cmd_req_o` stays high with a stable index and argument until `cmd_done_i`, then drops for at least one cycle before the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the sequence (taken only when idle) |
| tick_i | input | 1 | Time-base strobe for the polling limits |
| cmd_req_o | output | 1 | Command request, held until completion |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_exp_o | output | 1 | A response is expected |
| cmd_rsp_long_o | output | 1 | The response is 128 bits long |
| cmd_done_i | input | 1 | One-cycle command completion |
| cmd_rsp_i | input | 128 | Response bits; short responses in 31:0 |
| cmd_crc_err_i | input | 1 | Response CRC error, valid with completion |
| cmd_rsp_tmo_i | input | 1 | Response timeout, valid with completion |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| fail_o | output | 1 | One-cycle failure pulse, with done |
| err_code_o | output | 4 | Result code, 0 on success |
| v2_card_o | output | 1 | Card answered the interface-condition probe |
| ocr_o | output | 32 | Captured operating-condition word |
| cid_o | output | 128 | Captured identification register |
| rca_o | output | 16 | Captured relative card address |

## Verification
The properties rely on the command engine pulsing `cmd_done_i` for a single cycle and only while `cmd_req_o` is high, and on `start_i` never being raised before the asynchronous reset has been released. The bench card model meets this: it answers only a pending request, after a random delay of zero to three cycles. It clears its completion on the next falling edge, and it injects faults, busy rounds and probe replies only through the response bits and error flags of a real completion.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  localparam int IDX_W  = 6;
  localparam int ARG_W  = 32;
  localparam int CODE_W = 4;

  localparam logic [IDX_W-1:0] IDX_GO_IDLE   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_ALL_CID   = 6'd2;
  localparam logic [IDX_W-1:0] IDX_REL_ADDR  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BUS_WIDTH = 6'd6;
  localparam logic [IDX_W-1:0] IDX_SELECT    = 6'd7;
  localparam logic [IDX_W-1:0] IDX_IF_COND   = 6'd8;
  localparam logic [IDX_W-1:0] IDX_STATUS    = 6'd13;
  localparam logic [IDX_W-1:0] IDX_OP_COND   = 6'd41;
  localparam logic [IDX_W-1:0] IDX_APP       = 6'd55;

  localparam logic [ARG_W-1:0] ARG_IF_COND = 32'h0000_01AA;
  localparam logic [ARG_W-1:0] ARG_OP_VOLT = 32'h00FF_8000;
  localparam logic [ARG_W-1:0] ARG_HCS     = 32'h4000_0000;
  localparam logic [ARG_W-1:0] ARG_BUS4    = 32'h0000_0002;
  localparam logic [11:0]      ECHO_PATTERN = 12'h1AA;
  localparam logic [3:0]       CARD_STATE_TRAN = 4'd4;

  localparam logic [CODE_W-1:0] ERR_NONE         = 4'd0;
  localparam logic [CODE_W-1:0] ERR_APP_LOOP     = 4'd1;
  localparam logic [CODE_W-1:0] ERR_OP_RSP       = 4'd2;
  localparam logic [CODE_W-1:0] ERR_OP_TIMEOUT   = 4'd3;
  localparam logic [CODE_W-1:0] ERR_CID          = 4'd4;
  localparam logic [CODE_W-1:0] ERR_RCA          = 4'd5;
  localparam logic [CODE_W-1:0] ERR_STATUS_RSP   = 4'd6;
  localparam logic [CODE_W-1:0] ERR_TRAN_TIMEOUT = 4'd7;
  localparam logic [CODE_W-1:0] ERR_APP_BUS      = 4'd8;

  typedef enum logic [3:0] {
    STEP_GO_IDLE,
    STEP_IF_COND,
    STEP_APP_LOOP,
    STEP_OP_COND,
    STEP_GET_CID,
    STEP_GET_RCA,
    STEP_SELECT,
    STEP_POLL_STATE,
    STEP_APP_BUS,
    STEP_BUS_WIDTH
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_GAP
  } phase_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [ARG_W-1:0] arg;
    logic             rsp_exp;
    logic             rsp_long;
  } cmd_s;

endpackage

// File: rtl/sdinit_cmd_table.sv
module sdinit_cmd_table
  import sdinit_pkg::*;
#(
  parameter int RCA_W = 16
) (
  input  step_e            step_i,
  input  logic             v2_i,
  input  logic [RCA_W-1:0] rca_i,
  output cmd_s             cmd_o
);

  localparam int PAD_W = ARG_W - RCA_W;

  logic [ARG_W-1:0] rca_arg;

  assign rca_arg = {rca_i, {PAD_W{1'b0}}};

  always_comb begin
    cmd_o.idx      = IDX_GO_IDLE;
    cmd_o.arg      = '0;
    cmd_o.rsp_exp  = 1'b0;
    cmd_o.rsp_long = 1'b0;
    unique case (step_i)
      STEP_GO_IDLE: begin
        cmd_o.idx = IDX_GO_IDLE;
      end
      STEP_IF_COND: begin
        cmd_o.idx     = IDX_IF_COND;
        cmd_o.arg     = ARG_IF_COND;
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_APP_LOOP: begin
        cmd_o.idx     = IDX_APP;
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_OP_COND: begin
        cmd_o.idx     = IDX_OP_COND;
        cmd_o.arg     = ARG_OP_VOLT | (v2_i ? ARG_HCS : '0);
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_GET_CID: begin
        cmd_o.idx      = IDX_ALL_CID;
        cmd_o.rsp_exp  = 1'b1;
        cmd_o.rsp_long = 1'b1;
      end
      STEP_GET_RCA: begin
        cmd_o.idx     = IDX_REL_ADDR;
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_SELECT: begin
        cmd_o.idx = IDX_SELECT;
        cmd_o.arg = rca_arg;
      end
      STEP_POLL_STATE: begin
        cmd_o.idx     = IDX_STATUS;
        cmd_o.arg     = rca_arg;
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_APP_BUS: begin
        cmd_o.idx     = IDX_APP;
        cmd_o.arg     = rca_arg;
        cmd_o.rsp_exp = 1'b1;
      end
      STEP_BUS_WIDTH: begin
        cmd_o.idx = IDX_BUS_WIDTH;
        cmd_o.arg = ARG_BUS4;
      end
      default: begin
        cmd_o.idx = IDX_GO_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/sdinit_tick_timer.sv
module sdinit_tick_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  assign count_en = clr_i || (en_i && tick_i && (count_q != {CNT_W{1'b1}}));

  always_comb begin
    count_d = count_q + 1'b1;
    if (clr_i) begin
      count_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/sdinit_capture.sv
module sdinit_capture #(
  parameter int RSP_W = 128,
  parameter int OCR_W = 32,
  parameter int RCA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_ocr_i,
  input  logic             ld_cid_i,
  input  logic             ld_rca_i,
  input  logic [RSP_W-1:0] rsp_i,
  output logic [OCR_W-1:0] ocr_o,
  output logic [RSP_W-1:0] cid_o,
  output logic [RCA_W-1:0] rca_o
);

  localparam int RCA_LSB = OCR_W - RCA_W;

  logic [OCR_W-1:0] ocr_q;
  logic [RSP_W-1:0] cid_q;
  logic [RCA_W-1:0] rca_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_q <= '0;
    end else if (clr_i || ld_ocr_i) begin
      ocr_q <= clr_i ? '0 : rsp_i[OCR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cid_q <= '0;
    end else if (clr_i || ld_cid_i) begin
      cid_q <= clr_i ? '0 : rsp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rca_q <= '0;
    end else if (clr_i || ld_rca_i) begin
      rca_q <= clr_i ? '0 : rsp_i[OCR_W-1:RCA_LSB];
    end
  end

  assign ocr_o = ocr_q;
  assign cid_o = cid_q;
  assign rca_o = rca_q;

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int ACMD_TICKS   = 1000,
  parameter int STATUS_TICKS = 5000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         tick_i,
  output logic         cmd_req_o,
  output logic [5:0]   cmd_idx_o,
  output logic [31:0]  cmd_arg_o,
  output logic         cmd_rsp_exp_o,
  output logic         cmd_rsp_long_o,
  input  logic         cmd_done_i,
  input  logic [127:0] cmd_rsp_i,
  input  logic         cmd_crc_err_i,
  input  logic         cmd_rsp_tmo_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         fail_o,
  output logic [3:0]   err_code_o,
  output logic         v2_card_o,
  output logic [31:0]  ocr_o,
  output logic [127:0] cid_o,
  output logic [15:0]  rca_o
);

  localparam int RSP_W     = 128;
  localparam int OCR_W     = 32;
  localparam int RCA_W     = 16;
  localparam int LIMIT_MAX = (ACMD_TICKS > STATUS_TICKS) ? ACMD_TICKS : STATUS_TICKS;
  localparam int TMR_W     = $clog2(LIMIT_MAX + 1);
  localparam logic [TMR_W-1:0] ACMD_LIMIT   = TMR_W'(ACMD_TICKS);
  localparam logic [TMR_W-1:0] STATUS_LIMIT = TMR_W'(STATUS_TICKS);

  phase_e             phase_q, phase_d;
  step_e              step_q, step_d;
  logic               v2_q, v2_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               done_q, done_d;
  logic               fail_q, fail_d;

  logic               cap_clr, ld_ocr, ld_cid, ld_rca;
  logic               tmr_clr;
  logic               rsp_bad;
  logic               fin;
  logic [CODE_W-1:0]  fcode;
  logic [TMR_W-1:0]   elapsed;
  logic [RCA_W-1:0]   rca_w;
  cmd_s               cmd;

  sdinit_cmd_table #(
    .RCA_W (RCA_W)
  ) i_table (
    .step_i (step_q),
    .v2_i   (v2_q),
    .rca_i  (rca_w),
    .cmd_o  (cmd)
  );

  sdinit_tick_timer #(
    .CNT_W (TMR_W)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .en_i    (phase_q != PH_IDLE),
    .tick_i  (tick_i),
    .count_o (elapsed)
  );

  sdinit_capture #(
    .RSP_W (RSP_W),
    .OCR_W (OCR_W),
    .RCA_W (RCA_W)
  ) i_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cap_clr),
    .ld_ocr_i (ld_ocr),
    .ld_cid_i (ld_cid),
    .ld_rca_i (ld_rca),
    .rsp_i    (cmd_rsp_i),
    .ocr_o    (ocr_o),
    .cid_o    (cid_o),
    .rca_o    (rca_w)
  );

  assign rsp_bad = cmd.rsp_exp && (cmd_crc_err_i || cmd_rsp_tmo_i);

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    v2_d    = v2_q;
    code_d  = code_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    cap_clr = 1'b0;
    ld_ocr  = 1'b0;
    ld_cid  = 1'b0;
    ld_rca  = 1'b0;
    tmr_clr = 1'b0;
    fin     = 1'b0;
    fcode   = ERR_NONE;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_ISSUE;
          step_d  = STEP_GO_IDLE;
          v2_d    = 1'b0;
          code_d  = ERR_NONE;
          cap_clr = 1'b1;
        end
      end
      PH_ISSUE: begin
        if (cmd_done_i) begin
          phase_d = PH_GAP;
          unique case (step_q)
            STEP_GO_IDLE: begin
              step_d = STEP_IF_COND;
            end
            STEP_IF_COND: begin
              v2_d    = !rsp_bad && (cmd_rsp_i[11:0] == ECHO_PATTERN);
              step_d  = STEP_APP_LOOP;
              tmr_clr = 1'b1;
            end
            STEP_APP_LOOP: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_APP_LOOP;
              end else begin
                step_d = STEP_OP_COND;
              end
            end
            STEP_OP_COND: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_OP_RSP;
              end else if (cmd_rsp_i[OCR_W-1]) begin
                ld_ocr = 1'b1;
                step_d = STEP_GET_CID;
              end else if (elapsed >= ACMD_LIMIT) begin
                fin   = 1'b1;
                fcode = ERR_OP_TIMEOUT;
              end else begin
                step_d = STEP_APP_LOOP;
              end
            end
            STEP_GET_CID: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_CID;
              end else begin
                ld_cid = 1'b1;
                step_d = STEP_GET_RCA;
              end
            end
            STEP_GET_RCA: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_RCA;
              end else begin
                ld_rca = 1'b1;
                step_d = STEP_SELECT;
              end
            end
            STEP_SELECT: begin
              step_d  = STEP_POLL_STATE;
              tmr_clr = 1'b1;
            end
            STEP_POLL_STATE: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_STATUS_RSP;
              end else if (cmd_rsp_i[12:9] == CARD_STATE_TRAN) begin
                step_d = STEP_APP_BUS;
              end else if (elapsed >= STATUS_LIMIT) begin
                fin   = 1'b1;
                fcode = ERR_TRAN_TIMEOUT;
              end else begin
                step_d = STEP_POLL_STATE;
              end
            end
            STEP_APP_BUS: begin
              if (rsp_bad) begin
                fin   = 1'b1;
                fcode = ERR_APP_BUS;
              end else begin
                step_d = STEP_BUS_WIDTH;
              end
            end
            STEP_BUS_WIDTH: begin
              fin   = 1'b1;
              fcode = ERR_NONE;
            end
            default: begin
              fin   = 1'b1;
              fcode = ERR_NONE;
            end
          endcase
          if (fin) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
            fail_d  = (fcode != ERR_NONE);
            code_d  = fcode;
          end
        end
      end
      PH_GAP: begin
        phase_d = PH_ISSUE;
      end
      default: begin
        phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= STEP_GO_IDLE;
      v2_q    <= 1'b0;
      code_q  <= ERR_NONE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      v2_q    <= v2_d;
      code_q  <= code_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign cmd_req_o      = (phase_q == PH_ISSUE);
  assign cmd_idx_o      = cmd.idx;
  assign cmd_arg_o      = cmd.arg;
  assign cmd_rsp_exp_o  = cmd.rsp_exp;
  assign cmd_rsp_long_o = cmd.rsp_long;
  assign busy_o         = (phase_q != PH_IDLE);
  assign done_o         = done_q;
  assign fail_o         = fail_q;
  assign err_code_o     = code_q;
  assign v2_card_o      = v2_q;
  assign rca_o          = rca_w;

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         cmd_req_o,
  input logic [5:0]   cmd_idx_o,
  input logic [31:0]  cmd_arg_o,
  input logic         cmd_rsp_exp_o,
  input logic         cmd_done_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         fail_o,
  input logic [3:0]   err_code_o,
  input logic         v2_card_o,
  input logic [31:0]  ocr_o,
  input logic [127:0] cid_o,
  input logic [15:0]  rca_o
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_done_i |=> cmd_req_o && $stable(cmd_idx_o) && $stable(cmd_arg_o)); // R12

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && cmd_done_i |=> !cmd_req_o); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o && (err_code_o != 4'd0)); // R9

  AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fail_o |-> err_code_o == 4'd0); // R10

  AST_OP_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && cmd_idx_o == 6'd41 |->
      ((cmd_arg_o & 32'hBFFF_FFFF) == 32'h00FF_8000) && (cmd_arg_o[30] == v2_card_o)); // R4

  AST_WIDTH_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && cmd_idx_o == 6'd6 |-> cmd_arg_o == 32'd2 && !cmd_rsp_exp_o); // R8

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(ocr_o) && $stable(cid_o) && $stable(rca_o)); // R11

endmodule

bind sdinit_seq sdinit_seq_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .cmd_req_o     (cmd_req_o),
  .cmd_idx_o     (cmd_idx_o),
  .cmd_arg_o     (cmd_arg_o),
  .cmd_rsp_exp_o (cmd_rsp_exp_o),
  .cmd_done_i    (cmd_done_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fail_o        (fail_o),
  .err_code_o    (err_code_o),
  .v2_card_o     (v2_card_o),
  .ocr_o         (ocr_o),
  .cid_o         (cid_o),
  .rca_o         (rca_o)
);

// File: tb/test_sdinit_seq.sv
module test_sdinit_seq;

  localparam int CLK_PERIOD   = 10;
  localparam int ACMD_TICKS   = 20;
  localparam int STATUS_TICKS = 30;
  localparam int TICK_DIV     = 4;
  localparam int RUN_LIMIT    = 4000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         tick;
  logic         cmd_req;
  logic [5:0]   cmd_idx;
  logic [31:0]  cmd_arg;
  logic         cmd_rsp_exp;
  logic         cmd_rsp_long;
  logic         cmd_done;
  logic [127:0] cmd_rsp;
  logic         cmd_crc;
  logic         cmd_tmo;
  logic         busy;
  logic         done;
  logic         fail;
  logic [3:0]   err_code;
  logic         v2_card;
  logic [31:0]  ocr;
  logic [127:0] cid;
  logic [15:0]  rca;

  int checks;
  int errors;

  // scenario
  int           sc_fault;
  int           sc_v2mode;
  int           sc_acmd_left;
  int           sc_stat_left;
  bit           sc_noise;
  logic [30:0]  sc_ocr;
  logic [127:0] sc_cid;
  logic [15:0]  sc_rca;
  bit           rca_given;

  // observations
  int           cnt [64];
  logic [31:0]  last_arg [64];
  int           first_idx;
  int           last_idx;
  int           ncmd;

  sdinit_seq #(
    .ACMD_TICKS   (ACMD_TICKS),
    .STATUS_TICKS (STATUS_TICKS)
  ) i_sdinit_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .tick_i         (tick),
    .cmd_req_o      (cmd_req),
    .cmd_idx_o      (cmd_idx),
    .cmd_arg_o      (cmd_arg),
    .cmd_rsp_exp_o  (cmd_rsp_exp),
    .cmd_rsp_long_o (cmd_rsp_long),
    .cmd_done_i     (cmd_done),
    .cmd_rsp_i      (cmd_rsp),
    .cmd_crc_err_i  (cmd_crc),
    .cmd_rsp_tmo_i  (cmd_tmo),
    .busy_o         (busy),
    .done_o         (done),
    .fail_o         (fail),
    .err_code_o     (err_code),
    .v2_card_o      (v2_card),
    .ocr_o          (ocr),
    .cid_o          (cid),
    .rca_o          (rca)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick strobe
  initial begin
    tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // bench functions for expected values
  function automatic logic [3:0] exp_code(input int fault);
    return 4'(fault);
  endfunction

  function automatic logic [31:0] exp_op_arg(input bit v2);
    return 32'h00FF_8000 | (v2 ? 32'h4000_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] err_flags_hit(input int idx);
    case (idx)
      55: return (sc_fault == 1 && !rca_given) || (sc_fault == 8 && rca_given);
      41: return sc_fault == 2;
      2:  return sc_fault == 4;
      3:  return sc_fault == 5;
      13: return sc_fault == 6;
      default: return 0;
    endcase
  endfunction

  // card model
  task automatic serve();
    int i;
    i = int'(cmd_idx);
    cnt[i]++;
    last_arg[i] = cmd_arg;
    if (ncmd == 0) first_idx = i;
    last_idx = i;
    ncmd++;
    cmd_rsp = '0;
    if (err_flags_hit(i) != 0) begin
      if ($urandom_range(0, 1) == 1) cmd_crc = 1'b1;
      else cmd_tmo = 1'b1;
    end else begin
      case (i)
        0, 6, 7: if (sc_noise) cmd_crc = 1'b1;
        8: begin
          if (sc_v2mode == 0) cmd_tmo = 1'b1;
          else if (sc_v2mode == 1) cmd_rsp[11:0] = 12'h1AA;
          else cmd_rsp[11:0] = 12'h0AA;
        end
        41: begin
          if (sc_acmd_left > 0) begin
            sc_acmd_left--;
            cmd_rsp[31:0] = {1'b0, sc_ocr};
          end else begin
            cmd_rsp[31:0] = {1'b1, sc_ocr};
          end
        end
        2: cmd_rsp = sc_cid;
        3: begin
          cmd_rsp[31:0] = {sc_rca, 16'h0500};
          rca_given = 1'b1;
        end
        13: begin
          if (sc_stat_left > 0) begin
            sc_stat_left--;
            cmd_rsp[31:0] = 32'h0000_0100 | (32'd3 << 9);
          end else begin
            cmd_rsp[31:0] = 32'h0000_0100 | (32'd4 << 9);
          end
        end
        default: cmd_rsp = '0;
      endcase
    end
    cmd_done = 1'b1;
  endtask

  initial begin
    int lat;
    bit seen;
    logic [5:0]  seen_idx;
    logic [31:0] seen_arg;
    cmd_done = 1'b0;
    cmd_rsp  = '0;
    cmd_crc  = 1'b0;
    cmd_tmo  = 1'b0;
    lat      = 2;
    seen     = 1'b0;
    seen_idx = '0;
    seen_arg = '0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      cmd_crc  = 1'b0;
      cmd_tmo  = 1'b0;
      cmd_rsp  = '0;
      if (cmd_req) begin
        if (!seen) begin
          seen     = 1'b1;
          seen_idx = cmd_idx;
          seen_arg = cmd_arg;
        end
        if (lat == 0) begin
          // R12: request fields unchanged while waiting
          chk(cmd_idx == seen_idx && cmd_arg == seen_arg, "R12",
              {cmd_idx, cmd_arg}, {seen_idx, seen_arg});
          serve();
          seen = 1'b0;
          lat  = $urandom_range(0, 3);
        end else begin
          lat--;
        end
      end
    end
  end

  task automatic run_case(input int fault, input int v2mode, input int acmd_rounds,
                          input int stat_rounds, input bit noise, input bit poke);
    int   waited;
    bit   got;
    bit   v2e;
    logic [31:0] prev_ocr;
    sc_fault     = fault;
    sc_v2mode    = v2mode;
    sc_acmd_left = (fault == 3) ? 100000 : acmd_rounds;
    sc_stat_left = (fault == 7) ? 100000 : stat_rounds;
    sc_noise     = noise;
    sc_ocr       = 31'($urandom());
    sc_cid       = {$urandom(), $urandom(), $urandom(), $urandom()};
    sc_rca       = 16'($urandom_range(1, 65535));
    rca_given    = 1'b0;
    for (int k = 0; k < 64; k++) begin
      cnt[k]      = 0;
      last_arg[k] = '0;
    end
    ncmd      = 0;
    first_idx = -1;
    last_idx  = -1;
    v2e       = (v2mode == 1);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: accepted start clears captured results
    chk(rca == 16'h0 && ocr == 32'h0 && cid == 128'h0, "R11", {ocr, rca}, '0);

    waited = 0;
    got    = 1'b0;
    while (!got && waited < RUN_LIMIT) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 12) start = 1'b1;
      else start = 1'b0;
      if (done) got = 1'b1;
    end
    start = 1'b0;
    chk(got, "R10 done reached", 128'(got), 128'd1);
    if (!got) return;

    // R9 / R5 / R7 / R8: outcome code
    chk(err_code == exp_code(fault), "R9 code", 128'(err_code), 128'(exp_code(fault)));
    chk(fail == (fault != 0), "R10 fail", 128'(fail), 128'(fault != 0));
    chk(!busy, "R10 busy low at done", 128'(busy), 128'd0);
    // R2: first command and single start (R11 when poked)
    chk(first_idx == 0 && cnt[0] == 1 && last_arg[0] == 32'h0, "R2",
        128'(first_idx), 128'd0);
    if (poke) chk(cnt[0] == 1, "R11 start ignored", 128'(cnt[0]), 128'd1);
    // R3
    chk(cnt[8] == 1 && last_arg[8] == 32'h1AA, "R3 probe", 128'(last_arg[8]), 128'h1AA);
    chk(v2_card == v2e, "R3 v2", 128'(v2_card), 128'(v2e));
    // R4
    if (cnt[41] > 0)
      chk(last_arg[41] == exp_op_arg(v2e), "R4 arg", 128'(last_arg[41]),
          128'(exp_op_arg(v2e)));
    if (fault == 3)
      chk(cnt[41] >= 2 && cnt[2] == 0, "R5 timeout", 128'(cnt[2]), 128'd0);
    if (fault == 0) begin
      chk(ocr == {1'b1, sc_ocr}, "R4 ocr", 128'(ocr), 128'({1'b1, sc_ocr}));
      chk(cnt[41] == acmd_rounds + 1, "R4 rounds", 128'(cnt[41]), 128'(acmd_rounds + 1));
      chk(cid == sc_cid, "R6 cid", cid, sc_cid);
      chk(rca == sc_rca, "R6 rca", 128'(rca), 128'(sc_rca));
      chk(last_arg[7] == {sc_rca, 16'h0} && last_arg[13] == {sc_rca, 16'h0}, "R7 args",
          {last_arg[7], last_arg[13]}, {sc_rca, 16'h0, sc_rca, 16'h0});
      chk(cnt[13] == stat_rounds + 1, "R7 polls", 128'(cnt[13]), 128'(stat_rounds + 1));
      chk(last_arg[55] == {sc_rca, 16'h0} && last_arg[6] == 32'd2 && cnt[6] == 1 &&
          last_idx == 6, "R8 bus setup", 128'(last_arg[6]), 128'd2);
    end
    if (fault == 7)
      chk(cnt[13] >= 2 && cnt[6] == 0, "R7 timeout", 128'(cnt[6]), 128'd0);

    @(negedge clk);
    chk(!done && !fail, "R10 pulse width", 128'({done, fail}), 128'd0);
    // R11: results hold while idle
    prev_ocr = ocr;
    repeat (10) @(negedge clk);
    chk(ocr == prev_ocr && !busy && err_code == exp_code(fault), "R11 hold",
        128'(ocr), 128'(prev_ocr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    start  = 1'b0;
    rst_n  = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fail && !cmd_req && err_code == 4'd0, "R1 ctrl",
        128'({busy, done, fail, cmd_req, err_code}), 128'd0);
    chk(ocr == 32'h0 && cid == 128'h0 && rca == 16'h0 && !v2_card, "R1 results",
        {ocr, rca}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run_case(0, 1, 2, 2, 1'b0, 1'b0);
    run_case(0, 0, 0, 0, 1'b1, 1'b1);
    run_case(0, 2, 3, 0, 1'b1, 1'b0);
    for (int f = 1; f <= 8; f++) begin
      run_case(f, f % 3, 1, 1, 1'b0, 1'b0);
    end
    // random mix
    for (int n = 0; n < 30; n++) begin
      int f;
      f = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 8) : 0;
      run_case(f, $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule